// File: doc/BRIEF.md
# Stepped dB Digital Gain Stage

This block scales a complex baseband stream, I and Q together, by one gain picked from 43 settings that run from -3 dB to +18 dB in 0.5 dB steps. A 6-bit unsigned selector addresses a table of unsigned fixed-point linear gain words. The table is computed when the design is elaborated. Both lanes of a sample are multiplied by the same word. Each product is rounded half-up to a 21-bit intermediate and then clamped to a 16-bit signed result. It sits after I/Q imbalance correction. The usual setting is selector 29 (+11.5 dB): that makes up two bits of converter width and keeps 0.5 dB of headroom.

Samples enter and leave over valid/ready handshakes. A sample moves on an edge where valid and ready are both high. The input is ready whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the whole pipeline stops. The output holds its value and no sample is lost or repeated. The gain selector is a plain control pin. It is read on the edge where a sample is accepted, and that sample carries its gain word along with it.

Top module: `dbgain_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For a selector k from 0 to 42, the gain word is round(10^((0.5k-3)/20) * 65536). This is unsigned with 16 fraction bits, so selector 6 gives exactly 65536 (0 dB). The output is sat16((x * word + 32768) >>> 16).
- R3: Rounding is half-up: 32768 is added to the full product before the arithmetic right shift by 16.
- R4: A result above 32767 becomes 32767, and a result below -32768 becomes -32768.
- R5: A selector from 43 to 63 behaves exactly like selector 42 (+18 dB).
- R6: Each sample uses the selector value present on the edge where it is accepted. Later selector changes do not alter it, and its I and Q use the same word.
- R7: With `out_ready` held high, a sample accepted on one edge shows as `out_valid` after the second edge. Latency is two cycles.
- R8: While `out_valid` is high and `out_ready` is low, `out_i`/`out_q` stay stable and `in_ready` is low. Every accepted sample leaves exactly once, in order.
- R9: A zero sample gives zero, and a non-negative sample never gives a negative result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_sel | input | 6 | Gain selector, 0.5 dB per step from -3 dB |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input can accept a sample |
| in_i | input | 16 | Input I, signed |
| in_q | input | 16 | Input Q, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_i | output | 16 | Scaled I, signed |
| out_q | output | 16 | Scaled Q, signed |

## Verification
A selector change and an output stall can fall in the same cycle. One sample can be held in the output register while the next sits in stage one with a different gain word. The bench changes the selector on every accepted sample and drops `out_ready` and `in_valid` on irregular patterns, so such collisions happen often. Every output is compared in order against a value computed in the bench from the selector seen at acceptance, and held outputs are checked for stability.

// File: rtl/dbgain_pkg.sv
package dbgain_pkg;
  localparam int DATA_W    = 16;
  localparam int GAIN_W    = 20;
  localparam int FRAC_W    = 16;
  localparam int MID_W     = 21;
  localparam int NUM_STEPS = 43;
  localparam int IDX_W     = 6;

  // linear gain for step k: -3 dB times (0.5 dB)^k, scaled by 2^frac
  function automatic int gain_word(int k, int frac);
    real g;
    g = 0.7079457843841379;
    for (int n = 0; n < k; n++) g = g * 1.0592537251772889;
    return $rtoi(g * real'(1 << frac) + 0.5);
  endfunction
endpackage

// File: rtl/dbgain_rom.sv
module dbgain_rom #(
  parameter int NUM_STEPS = dbgain_pkg::NUM_STEPS,
  parameter int IDX_W     = dbgain_pkg::IDX_W,
  parameter int GAIN_W    = dbgain_pkg::GAIN_W,
  parameter int FRAC_W    = dbgain_pkg::FRAC_W
) (
  input  logic [IDX_W-1:0]  sel,
  output logic [GAIN_W-1:0] word
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_STEPS - 1);

  logic [GAIN_W-1:0] table_w [NUM_STEPS];
  logic [IDX_W-1:0]  sel_c;

  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_entry
    assign table_w[k] = GAIN_W'(dbgain_pkg::gain_word(k, FRAC_W));
  end

  // out-of-range selectors clamp to the top step
  assign sel_c = (sel > TOP_IDX) ? TOP_IDX : sel;
  assign word  = table_w[sel_c];
endmodule

// File: rtl/dbgain_lane.sv
module dbgain_lane #(
  parameter int DATA_W = dbgain_pkg::DATA_W,
  parameter int GAIN_W = dbgain_pkg::GAIN_W,
  parameter int FRAC_W = dbgain_pkg::FRAC_W,
  parameter int MID_W  = dbgain_pkg::MID_W
) (
  input  logic signed [DATA_W-1:0] smp,
  input  logic        [GAIN_W-1:0] gw,
  output logic signed [DATA_W-1:0] res
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [MID_W-1:0] POS_MAX = MID_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [MID_W-1:0] NEG_MIN = -MID_W'(1 << (DATA_W - 1));
  localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1 << (FRAC_W - 1));

  logic signed [PROD_W-1:0] prod, biased;
  logic signed [MID_W-1:0]  mid;

  assign prod   = PROD_W'(smp) * $signed({1'b0, gw});
  assign biased = prod + HALF;
  assign mid    = biased[FRAC_W +: MID_W];

  always_comb begin
    if (mid > POS_MAX)      res = POS_MAX[DATA_W-1:0];
    else if (mid < NEG_MIN) res = NEG_MIN[DATA_W-1:0];
    else                    res = mid[DATA_W-1:0];
  end

  always_comb begin
    if (smp == '0) assert_zero_in_R9: assert (res == '0);
    if (!smp[DATA_W-1]) assert_sign_kept_R9: assert (!res[DATA_W-1]);
  end
endmodule

// File: rtl/dbgain_stage.sv
module dbgain_stage #(
  parameter int DATA_W    = dbgain_pkg::DATA_W,
  parameter int GAIN_W    = dbgain_pkg::GAIN_W,
  parameter int FRAC_W    = dbgain_pkg::FRAC_W,
  parameter int MID_W     = dbgain_pkg::MID_W,
  parameter int NUM_STEPS = dbgain_pkg::NUM_STEPS,
  parameter int IDX_W     = dbgain_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  gain_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  localparam int LANES = 2;

  logic              adv;
  logic [GAIN_W-1:0] rom_word, s1_gw;
  logic              s1_valid;
  logic [DATA_W-1:0] lane_in [LANES];
  logic [DATA_W-1:0] s1_smp  [LANES];
  logic [DATA_W-1:0] lane_res[LANES];
  logic [DATA_W-1:0] out_r   [LANES];

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  dbgain_rom #(
    .NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
  ) u_rom (
    .sel (gain_sel),
    .word(rom_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  // gain word travels with its sample
  always_ff @(posedge clk) begin
    if (adv && in_valid) s1_gw <= rom_word;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (adv && in_valid) s1_smp[l] <= lane_in[l];
      if (adv && s1_valid) out_r[l]  <= lane_res[l];
    end

    dbgain_lane #(
      .DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .MID_W(MID_W)
    ) u_lane (
      .smp(s1_smp[l]),
      .gw (s1_gw),
      .res(lane_res[l])
    );
  end

  assign out_i = out_r[0];
  assign out_q = out_r[1];

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  assert_two_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));
endmodule

// File: tb/test_dbgain_stage.sv
module test_dbgain_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  gain_sel = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0, in_q = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_i, out_q;

  int checks = 0, fails = 0;
  int exp_i[$], exp_q[$];
  string exp_r[$];
  bit prev_stall = 1'b0;
  logic [15:0] held_i, held_q;

  always #4 clk = ~clk;

  dbgain_stage i_dbgain_stage (
    .clk(clk), .rst_n(rst_n), .gain_sel(gain_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  function automatic int model(int k, int x);
    int kk;
    longint w, p, r;
    kk = (k > 42) ? 42 : k;
    w = longint'($rtoi($pow(10.0, (real'(kk) * 0.5 - 3.0) / 20.0) * 65536.0 + 0.5));
    p = longint'(x) * w;
    r = (p + 64'sd32768) >>> 16;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(bit iv, int xi, int xq, int idx, bit ordy, string req);
    int ei, eq;
    string er;
    @(negedge clk);
    in_valid = iv; in_i = 16'(xi); in_q = 16'(xq);
    gain_sel = 6'(idx); out_ready = ordy;
    #1;
    if (prev_stall) begin
      chk(out_valid, "R8", "held valid", int'(out_valid), 1);
      chk(out_i == held_i && out_q == held_q, "R8", "held I", int'($signed(out_i)), int'($signed(held_i)));
    end
    if (out_valid && !out_ready) chk(!in_ready, "R8", "in_ready in stall", int'(in_ready), 0);
    prev_stall = out_valid && !out_ready;
    held_i = out_i; held_q = out_q;
    if (out_valid && out_ready) begin
      if (exp_i.size() == 0) chk(1'b0, "R8", "extra output", 1, 0);
      else begin
        ei = exp_i.pop_front(); eq = exp_q.pop_front(); er = exp_r.pop_front();
        chk(int'($signed(out_i)) == ei, er, "out_i", int'($signed(out_i)), ei);
        chk(int'($signed(out_q)) == eq, er, "out_q", int'($signed(out_q)), eq);
      end
    end
    if (in_valid && in_ready) begin
      exp_i.push_back(model(idx, xi));
      exp_q.push_back(model(idx, xq));
      exp_r.push_back(req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int vals[10];
    string rq;
    // R3 odd and small values, R4 extremes, R9 zero
    vals = '{0, 1, -1, 2, -2, 32767, -32768, 12345, -20000, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);

    // R7 latency with out_ready high
    cycle(1, 1000, -1000, 29, 1, "R2");
    cycle(0, 0, 0, 29, 1, "R7");
    chk(!out_valid, "R7", "valid after one edge", int'(out_valid), 0);
    cycle(0, 0, 0, 29, 1, "R7");
    chk(out_valid, "R7", "valid after two edges", int'(out_valid), 1);
    cycle(0, 0, 0, 29, 1, "R7");

    // full selector sweep including clamped codes (R5)
    for (int k = 0; k < 64; k++) begin
      for (int v = 0; v < 10; v++) begin
        if (k > 42) rq = "R5";
        else if (vals[v] == 0) rq = "R9";
        else if (v == 5 || v == 6) rq = "R4";
        else if (v < 5 || v == 9) rq = "R3";
        else rq = "R2";
        cycle(1, vals[v], vals[9 - v], k, 1, rq);
      end
    end

    // R6 selector changes per sample while stalls and gaps occur (R8)
    for (int n = 0; n < 500; n++) begin
      cycle((n % 7) != 3, ((n * 7919) % 65536) - 32768, ((n * 104729) % 65536) - 32768,
            (n * 17) % 64, ((n % 5) != 1) && ((n % 11) != 4), "R6");
    end

    for (int d = 0; d < 20; d++) cycle(0, 0, 0, 0, 1, "R8");
    chk(exp_i.size() == 0, "R8", "samples left undelivered", exp_i.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule